// File: doc/BRIEF.md
# Packed Q-format multi-precision multiply-accumulate

This datapath treats each of two 32-bit operands as a pair of signed 16-bit half-words. It forms two signed products from a chosen pairing of those half-words and adds the products together. The sum is moved up by 16 bit positions and added to a signed 64-bit accumulator value. A pulse on `start` loads the result into an output register one clock later, and `res_vld` marks that cycle.

A one-bit Q-format control doubles each product so that fractional operands stay aligned. When the control is set and both factors of a product are the most negative half-word, that product is forced to the largest positive 32-bit value. This keeps the square of -1.0 from turning into a negative number.

The final 64-bit addition either wraps or clamps to the signed 64-bit limits, depending on a per-operation flag. The block is meant to be used as a multi-precision accumulation step: the caller feeds the previous result back in as the addend.

Top module: `pqmac_top`

## Requirements
- R1: A synchronous active-high `rst` clears `res` to zero and `res_vld` to 0 at the next rising clock edge, whatever the other inputs are.
- R2: `res_vld` is 1 in exactly the cycle after a cycle in which `start` was 1 and is 0 otherwise. `res` changes only after a `start` cycle and holds its value while `start` is 0, even when the data inputs change.
- R3: `pair_sel` chooses the factors as follows. Product one is always `opa[31:16]` times a half of `opb`; product two is always `opa[15:0]` times a half of `opb`. `pair_sel[1]` picks the half of `opb` for product one and `pair_sel[0]` picks it for product two, where 1 means `opb[31:16]` and 0 means `opb[15:0]`. This gives 00 = LL, 01 = LU, 10 = UL and 11 = UU.
- R4: Each product is the signed 16x16 product of its two factors, shifted left by one bit when `qshift` is 1 and left unshifted when it is 0.
- R5: When `qshift` is 1 and both factors of a product are 0x8000, that product is 0x7FFFFFFF. When `qshift` is 0, the same factors give 0x40000000.
- R6: The two 32-bit products are added at full precision, so a carry out of bit 31 is kept. That sum is multiplied by 2^16, sign-extended to 64 bits and added to `acc_in`.
- R7: When `sat_en` is 0, `res` is the low 64 bits of that addition, so a signed overflow wraps around.
- R8: When `sat_en` is 1 and the addition overflows, `res` is 0x7FFFFFFFFFFFFFFF for a positive overflow and 0x8000000000000000 for a negative overflow.
- R9: When the addition does not overflow, `sat_en` has no effect on `res`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches one operation on the current inputs |
| opa | input | 32 | First packed operand (two signed half-words) |
| opb | input | 32 | Second packed operand (two signed half-words) |
| acc_in | input | 64 | Signed 64-bit addend |
| pair_sel | input | 2 | Half-word pairing mode (LL, LU, UL, UU) |
| qshift | input | 1 | Q-format left shift of each product by one bit |
| sat_en | input | 1 | 1 = clamp on signed 64-bit overflow, 0 = wrap |
| res | output | 64 | Registered 64-bit result |
| res_vld | output | 1 | High for the cycle in which a new result is presented |

## Verification
The bench sends each pairing mode operands whose four half-words are all different. A crossed select line therefore yields a visibly different product instead of an accidental match. The 0x8000 x 0x8000 case is run with `qshift` set and clear, and the clamp is also placed in one product while the other product holds 0x8000 with a different partner. A wrongly placed or missing clamp turns the result negative, or clamps the wrong product.

Two clamped or near-maximum products are summed so that the carry out of bit 31 matters. A 32-bit sum would drop it and flip the sign of the added term. Addends at the positive and negative 64-bit limits are applied with `sat_en` low and high, and the bench expects a wrapped value, the correct extreme, and no clamp at all for results that do not overflow. A mistake in the direction of the overflow test would pick the wrong extreme or clamp results that are in range.

// File: rtl/pqmac_pkg.sv
package pqmac_pkg;

   // Half-word pairing; bit 1 picks the opb half for product one,
   // bit 0 picks the opb half for product two (1 = upper half).
   typedef enum logic [1:0] {
      PAIR_LL = 2'b00,
      PAIR_LU = 2'b01,
      PAIR_UL = 2'b10,
      PAIR_UU = 2'b11
   } pair_e;

   localparam int unsigned NUM_PROD = 2;

endpackage

// File: rtl/pqmac_halfsel.sv
module pqmac_halfsel
   import pqmac_pkg::*;
#(
   parameter int unsigned HW = 16
) (
   input  logic [2*HW-1:0] opa,
   input  logic [2*HW-1:0] opb,
   input  pair_e           pair_sel,
   output logic [HW-1:0]   fa [NUM_PROD],
   output logic [HW-1:0]   fb [NUM_PROD]
);

   localparam int unsigned DW = 2 * HW;

   if (HW < 2) begin : g_bad_hw
      $error("pqmac_halfsel: HW must be at least 2");
   end

   // Product 0 takes the upper half of opa, product 1 the lower half.
   // Its opb half is chosen by pair_sel[1] or pair_sel[0] respectively.
   for (genvar g = 0; g < NUM_PROD; g++) begin : g_pick
      localparam int unsigned SELBIT = NUM_PROD - 1 - g;
      logic [HW-1:0] a_hi, a_lo, b_hi, b_lo;
      assign a_hi = opa[DW-1:HW];
      assign a_lo = opa[HW-1:0];
      assign b_hi = opb[DW-1:HW];
      assign b_lo = opb[HW-1:0];
      assign fa[g] = (g == 0) ? a_hi : a_lo;
      assign fb[g] = pair_sel[SELBIT] ? b_hi : b_lo;
   end

endmodule

// File: rtl/pqmac_qmul.sv
module pqmac_qmul #(
   parameter int unsigned HW = 16
) (
   input  logic [HW-1:0]   fa,
   input  logic [HW-1:0]   fb,
   input  logic            qshift,
   output logic [2*HW-1:0] prod
);

   localparam int unsigned PW   = 2 * HW;
   localparam logic [HW-1:0] MOST_NEG = {1'b1, {(HW-1){1'b0}}};
   localparam logic [PW-1:0] POS_MAX  = {1'b0, {(PW-1){1'b1}}};

   logic signed [PW-1:0] full;
   logic [PW-1:0]        scaled;
   logic                 clamp;

   assign full   = $signed(fa) * $signed(fb);
   assign scaled = qshift ? {full[PW-2:0], 1'b0} : full;
   assign clamp  = qshift && (fa == MOST_NEG) && (fb == MOST_NEG);
   assign prod   = clamp ? POS_MAX : scaled;

   // A product of two nonzero factors carries the sign of their XOR.
   always_comb begin
      if (!$isunknown({fa, fb, qshift}) && (fa != '0) && (fb != '0)) begin
         AST_PROD_SIGN: assert (prod[PW-1] == (fa[HW-1] ^ fb[HW-1])); // R5
      end
   end

endmodule

// File: rtl/pqmac_accum.sv
module pqmac_accum #(
   parameter int unsigned PW          = 32,
   parameter int unsigned AW          = 64,
   parameter int unsigned SHIFT       = 16,
   parameter bit          SAT_SUPPORT = 1'b1
) (
   input  logic [PW-1:0] p0,
   input  logic [PW-1:0] p1,
   input  logic [AW-1:0] acc_in,
   input  logic          sat_en,
   output logic [AW-1:0] sum
);

   localparam int unsigned SW  = PW + 1;
   localparam int unsigned PAD = AW - SW - SHIFT;
   localparam logic [AW-1:0] POS_LIM = {1'b0, {(AW-1){1'b1}}};
   localparam logic [AW-1:0] NEG_LIM = {1'b1, {(AW-1){1'b0}}};

   if (AW < SW + SHIFT + 1) begin : g_bad_aw
      $error("pqmac_accum: AW too small for the shifted product sum");
   end

   logic [SW-1:0] psum;
   logic [AW-1:0] addend;
   logic [AW-1:0] raw;
   logic          ovf;

   assign psum   = {p0[PW-1], p0} + {p1[PW-1], p1};
   assign addend = {{PAD{psum[SW-1]}}, psum, {SHIFT{1'b0}}};
   assign raw    = acc_in + addend;
   assign ovf    = (acc_in[AW-1] == addend[AW-1]) && (raw[AW-1] != acc_in[AW-1]);

   if (SAT_SUPPORT) begin : g_sat
      assign sum = (sat_en && ovf) ? (acc_in[AW-1] ? NEG_LIM : POS_LIM) : raw;

      // A clamped sum never has a sign opposite to both addends.
      always_comb begin
         if (!$isunknown({acc_in, addend, sat_en}) && sat_en) begin
            AST_SAT_SIGN: assert ((sum[AW-1] == acc_in[AW-1]) || (sum[AW-1] == addend[AW-1])); // R8
         end
      end
   end else begin : g_wrap
      logic unused_sat;
      assign unused_sat = sat_en ^ ovf;
      assign sum = raw;
   end

endmodule

// File: rtl/pqmac_top.sv
module pqmac_top
   import pqmac_pkg::*;
#(
   parameter int unsigned HW          = 16,
   parameter int unsigned AW          = 64,
   parameter bit          SAT_SUPPORT = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic [2*HW-1:0] opa,
   input  logic [2*HW-1:0] opb,
   input  logic [AW-1:0]   acc_in,
   input  logic [1:0]      pair_sel,
   input  logic            qshift,
   input  logic            sat_en,
   output logic [AW-1:0]   res,
   output logic            res_vld
);

   localparam int unsigned PW = 2 * HW;

   if (AW < PW + HW + 2) begin : g_bad_cfg
      $error("pqmac_top: AW must exceed 3*HW+1");
   end

   logic [HW-1:0] fa [NUM_PROD];
   logic [HW-1:0] fb [NUM_PROD];
   logic [PW-1:0] prod [NUM_PROD];
   logic [AW-1:0] sum_next;

   pqmac_halfsel #(.HW(HW)) u_sel (
      .opa      (opa),
      .opb      (opb),
      .pair_sel (pair_e'(pair_sel)),
      .fa       (fa),
      .fb       (fb)
   );

   for (genvar g = 0; g < NUM_PROD; g++) begin : g_mul
      pqmac_qmul #(.HW(HW)) u_mul (
         .fa     (fa[g]),
         .fb     (fb[g]),
         .qshift (qshift),
         .prod   (prod[g])
      );
   end

   pqmac_accum #(
      .PW          (PW),
      .AW          (AW),
      .SHIFT       (HW),
      .SAT_SUPPORT (SAT_SUPPORT)
   ) u_acc (
      .p0     (prod[0]),
      .p1     (prod[1]),
      .acc_in (acc_in),
      .sat_en (sat_en),
      .sum    (sum_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res     <= '0;
         res_vld <= 1'b0;
      end else begin
         res_vld <= start;
         if (start) begin
            res <= sum_next;
         end
      end
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (res == '0) && !res_vld); // R1
   AST_VLD_AFTER_START: assert property (@(posedge clk) disable iff (rst) start |=> res_vld); // R2
   AST_VLD_QUIET: assert property (@(posedge clk) disable iff (rst) !start |=> !res_vld); // R2
   AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst) !start |=> $stable(res)); // R2

endmodule

// File: tb/pqmac_top_tb.sv
`timescale 1ns/1ps
module pqmac_top_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic [63:0] acc_in = '0;
   logic [1:0]  pair_sel = '0;
   logic        qshift = 1'b0;
   logic        sat_en = 1'b0;
   logic [63:0] res;
   logic        res_vld;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    armed = 1'b0;
   bit    done  = 1'b0;
   string cur_req = "R1";

   logic [63:0] m_res = '0;
   logic        m_vld = 1'b0;

   always #5 clk = ~clk;

   pqmac_top u_dut (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .opa      (opa),
      .opb      (opb),
      .acc_in   (acc_in),
      .pair_sel (pair_sel),
      .qshift   (qshift),
      .sat_en   (sat_en),
      .res      (res),
      .res_vld  (res_vld)
   );

   // R4, R5: one Q-format product
   function automatic longint qprod(logic [15:0] x, logic [15:0] y, logic n);
      longint p;
      if (n && x == 16'h8000 && y == 16'h8000) return 64'h7FFF_FFFF;
      p = longint'($signed(x)) * longint'($signed(y));
      return n ? p * 2 : p;
   endfunction

   // R3, R6, R7, R8, R9: full expected result
   function automatic logic [63:0] ref_calc(logic [31:0] a, logic [31:0] b,
                                            logic [63:0] acc, logic [1:0] sel,
                                            logic n, logic sat);
      logic [15:0] b1, b2;
      longint s;
      logic signed [65:0] es, ea, tot;
      b1 = sel[1] ? b[31:16] : b[15:0];
      b2 = sel[0] ? b[31:16] : b[15:0];
      s  = qprod(a[31:16], b1, n) + qprod(a[15:0], b2, n);
      es = s;
      es = es * 66'sd65536;
      ea = $signed({{2{acc[63]}}, acc});
      tot = ea + es;
      if (sat && (tot[65:63] != 3'b000) && (tot[65:63] != 3'b111))
         return tot[65] ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF;
      return tot[63:0];
   endfunction

   // Cycle model
   always @(posedge clk) begin
      armed = 1'b1;
      if (rst) begin
         m_res = '0;
         m_vld = 1'b0;
      end else begin
         m_vld = start;
         if (start) m_res = ref_calc(opa, opb, acc_in, pair_sel, qshift, sat_en);
      end
   end

   always @(negedge clk) begin
      if (armed && !done) begin
         n_chk++;
         if (res !== m_res || res_vld !== m_vld) begin
            n_bad++;
            $display("FAIL %s: res=%h vld=%b expected res=%h vld=%b",
                     cur_req, res, res_vld, m_res, m_vld);
         end
      end
   end

   task automatic op(logic [31:0] a, logic [31:0] b, logic [63:0] acc,
                     logic [1:0] sel, logic n, logic sat);
      opa = a; opb = b; acc_in = acc; pair_sel = sel; qshift = n; sat_en = sat;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
   endtask

   task automatic idle(int k);
      for (int i = 0; i < k; i++) begin
         opa = $urandom; opb = $urandom; acc_in = {$urandom, $urandom};
         pair_sel = 2'($urandom); qshift = 1'($urandom); sat_en = 1'($urandom);
         @(posedge clk); #1;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: run did not complete");
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      idle(2);

      // R3: every pairing with distinct half-words
      cur_req = "R3";
      for (int m = 0; m < 4; m++) begin
         op(32'h0003_0005, 32'h0007_000B, 64'd0, 2'(m), 1'b0, 1'b0);
         op(32'hFFFD_1234, 32'h8001_7FF0, 64'h0000_0001_0000_0000, 2'(m), 1'b1, 1'b0);
      end
      idle(1);

      // R4: shift on and off, signed factors
      cur_req = "R4";
      op(32'hFFFF_0002, 32'h0003_FFFE, 64'd0, 2'b00, 1'b0, 1'b0);
      op(32'hFFFF_0002, 32'h0003_FFFE, 64'd0, 2'b00, 1'b1, 1'b0);
      op(32'h7FFF_8000, 32'h7FFF_8001, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 1'b1, 1'b0);

      // R5: most-negative squared, with and without shift
      cur_req = "R5";
      op(32'h8000_8000, 32'h8000_8000, 64'd0, 2'b00, 1'b1, 1'b0);
      op(32'h8000_8000, 32'h8000_8000, 64'd0, 2'b00, 1'b0, 1'b0);
      op(32'h8000_8000, 32'h8000_7FFF, 64'd0, 2'b10, 1'b1, 1'b0);
      op(32'h8000_8000, 32'h8000_7FFF, 64'd0, 2'b01, 1'b1, 1'b0);

      // R6: carry out of the 32-bit product sum
      cur_req = "R6";
      op(32'h8000_8000, 32'h0000_8000, 64'd0, 2'b00, 1'b1, 1'b0);
      op(32'h7FFF_7FFF, 32'h7FFF_7FFF, 64'd5, 2'b11, 1'b1, 1'b1);
      op(32'h8000_8000, 32'h7FFF_7FFF, 64'd0, 2'b00, 1'b1, 1'b0);

      // R7: wrap with saturation off
      cur_req = "R7";
      op(32'h4000_0000, 32'h0000_4000, 64'h7FFF_FFFF_FFFF_FFFF, 2'b00, 1'b0, 1'b0);
      op(32'h8000_0000, 32'h0000_7FFF, 64'h8000_0000_0000_0000, 2'b00, 1'b1, 1'b0);

      // R8: clamp at both limits
      cur_req = "R8";
      op(32'h4000_0000, 32'h0000_4000, 64'h7FFF_FFFF_FFFF_FFFF, 2'b00, 1'b0, 1'b1);
      op(32'h8000_0000, 32'h0000_7FFF, 64'h8000_0000_0000_0000, 2'b00, 1'b1, 1'b1);
      op(32'h8000_8000, 32'h8000_8000, 64'h7FFF_FFFF_0000_0000, 2'b11, 1'b1, 1'b1);

      // R9: no overflow, saturation makes no difference
      cur_req = "R9";
      op(32'h1234_8765, 32'hFEDC_0A0B, 64'h7FFF_0000_0000_0000, 2'b01, 1'b1, 1'b1);
      op(32'h1234_8765, 32'hFEDC_0A0B, 64'h8000_1000_0000_0000, 2'b10, 1'b0, 1'b1);

      // R2: hold during idle cycles with changing inputs
      cur_req = "R2";
      idle(6);

      // Mixed random traffic, with 0x8000 half-words and limit addends
      cur_req = "R3/R6/R8 random";
      for (int i = 0; i < 400; i++) begin
         logic [31:0] ra, rb;
         logic [63:0] rc;
         ra = $urandom; rb = $urandom; rc = {$urandom, $urandom};
         if ((i % 5) == 0) ra[31:16] = 16'h8000;
         if ((i % 7) == 0) rb[15:0]  = 16'h8000;
         if ((i % 6) == 0) rb[31:16] = 16'h8000;
         if ((i % 9) == 0) rc = 64'h7FFF_FFFF_FFF0_0000;
         if ((i % 11) == 0) rc = 64'h8000_0000_000F_0000;
         op(ra, rb, rc, 2'($urandom), 1'($urandom), 1'($urandom));
         if ((i % 13) == 0) idle(2);
      end

      // R1: reset in the middle of a start
      cur_req = "R1";
      op(32'h7FFF_7FFF, 32'h7FFF_7FFF, 64'd99, 2'b11, 1'b1, 1'b0);
      rst = 1'b1;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      @(posedge clk); #1;
      rst = 1'b0;
      idle(2);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule